// File: doc/BRIEF.md
# Speculation Poison-Bit Register File

This block is a 32-entry, 64-bit general register file. Each entry has one extra poison bit that marks a deferred fault. Speculative operations never trap. A speculative load that meets a fault, or that takes its address from a poisoned register, writes its result and sets the poison bit of its destination. A speculative arithmetic operation sets the poison bit of its destination when either of its sources is poisoned. The mark therefore follows a chain of dependent speculative results.

A verify operation names one register and a recovery address. If that register is poisoned, the block raises a one-cycle redirect carrying the address, and recovery code can then re-run the chain without speculation. A non-speculative operation that meets poison, or a fault, does not write its destination. It raises an immediate fault flag on its own lane instead.

There are two write lanes, numbered 0 and 1, and two combinational read ports. Memory, the fault sources and the recovery code lie outside the block. The verify path is a two-state machine. `CHK_IDLE` moves to `CHK_FIRE` when a verify hits a poisoned register. `CHK_FIRE` stays in `CHK_FIRE` on a further hit and returns to `CHK_IDLE` otherwise. `redirect_o` is high only in `CHK_FIRE`.

Top module: `tokreg_file`

## Requirements
- R1: A speculative load (op code 2) whose fault input is high writes its destination and sets that destination's poison bit. Its lane's fault flag stays low.
- R2: Poison is carried forward. A speculative load (op 2) sets the destination poison bit when its address register (source A) is poisoned. A speculative arithmetic operation (op 4) sets it when source A or source B is poisoned. A single verify on the end of a two-load chain therefore catches a fault in the first load.
- R3: A verify (chk_valid_i high) on a poisoned register drives redirect_o high for exactly the next cycle, with redirect_pc_o equal to the chk_target_i given with it.
- R4: A verify on a clean register leaves redirect_o low and changes no register.
- R5: When it meets no poison and no fault, a non-speculative load (op 1) or arithmetic operation (op 3) writes its data and clears the destination poison bit. Op 0 does nothing.
- R6: A non-speculative load (op 1) with a poisoned address or a high fault input, or an arithmetic operation (op 3) with a poisoned source, leaves its destination unchanged and drives fault_o of its lane high in the next cycle.
- R7: Register 0 always reads as zero with its poison bit clear, and every write to it is ignored.
- R8: When both lanes write the same register in one cycle, lane 1's data and poison bit are kept.
- R9: Source poison bits and the verify lookup use the register state from before the clock edge. A lane does not see a value that the other lane writes in the same cycle.
- R10: After reset, all registers are zero and clean, and fault_o and redirect_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_op_i | input | 6 | Op code per lane, 3 bits each, lane 0 in the low bits |
| wr_dst_i | input | 10 | Destination register per lane |
| wr_srca_i | input | 10 | Source A per lane, also the load address register |
| wr_srcb_i | input | 10 | Source B per lane |
| wr_data_i | input | 128 | Result data per lane |
| wr_fault_i | input | 2 | Fault condition seen by each lane's load |
| chk_valid_i | input | 1 | Verify operation present |
| chk_reg_i | input | 5 | Register to verify |
| chk_target_i | input | 64 | Recovery address for the verify |
| rd_addr_i | input | 10 | Read port addresses |
| rd_data_o | output | 128 | Read port data |
| rd_tok_o | output | 2 | Read port poison bits |
| fault_o | output | 2 | Immediate fault flag per lane, one cycle after the operation |
| redirect_o | output | 1 | Recovery redirect pulse |
| redirect_pc_o | output | 64 | Recovery address, valid while redirect_o is high |

## Verification
The properties take the op fields to hold only codes 0 to 4, and they sample every lane input and verify input at the rising edge. Codes 5 to 7 are decoded as no-ops, but no property covers them. The stimulus changes every input on the falling edge and draws op codes only from 0 to 4. Fault inputs are drawn about one time in four, so clean and poisoned chains both occur often. Directed cases cover register 0, the clash between lanes, chains and the ordering within one cycle.

// File: rtl/tokreg_pkg.sv
`timescale 1ns/1ps
package tokreg_pkg;
    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_LD   = 3'd1,
        OP_LDS  = 3'd2,
        OP_ALU  = 3'd3,
        OP_ALUS = 3'd4
    } op_e;

    typedef enum logic {
        CHK_IDLE = 1'b0,
        CHK_FIRE = 1'b1
    } chk_state_e;
endpackage

// File: rtl/tokreg_lane.sv
`timescale 1ns/1ps
module tokreg_lane
    import tokreg_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [2:0]    op_i,
    input  logic [AW-1:0] dst_i,
    input  logic          fault_i,
    input  logic          tok_a_i,
    input  logic          tok_b_i,
    output logic          we_o,
    output logic          tok_o,
    output logic          fault_o
);
    logic we_raw;

    always_comb begin
        we_raw  = 1'b0;
        tok_o   = 1'b0;
        fault_o = 1'b0;
        case (op_i)
            OP_LD: begin
                if (fault_i || tok_a_i) fault_o = 1'b1;
                else                    we_raw  = 1'b1;
            end
            OP_LDS: begin
                we_raw = 1'b1;
                tok_o  = fault_i | tok_a_i;
            end
            OP_ALU: begin
                if (tok_a_i || tok_b_i) fault_o = 1'b1;
                else                    we_raw  = 1'b1;
            end
            OP_ALUS: begin
                we_raw = 1'b1;
                tok_o  = tok_a_i | tok_b_i;
            end
            default: ;
        endcase
    end

    assign we_o = we_raw && (dst_i != '0);
endmodule

// File: rtl/tokreg_store.sv
`timescale 1ns/1ps
module tokreg_store #(
    parameter int NREG = 32,
    parameter int DW   = 64,
    parameter int NWR  = 2,
    parameter int NRD  = 2,
    parameter int AW   = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NWR-1:0]    we_i,
    input  logic [NWR*AW-1:0] waddr_i,
    input  logic [NWR*DW-1:0] wdata_i,
    input  logic [NWR-1:0]    wtok_i,
    input  logic [NRD*AW-1:0] raddr_i,
    output logic [NRD*DW-1:0] rdata_o,
    output logic [NRD-1:0]    rtok_o,
    output logic [NREG-1:0]   tok_all_o
);
    localparam int TOP = NWR - 1;

    logic [DW-1:0]   mem_q [NREG];
    logic [NREG-1:0] tok_q;

    // later lanes are applied last, so the highest lane wins a clash
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) mem_q[r] <= '0;
            tok_q <= '0;
        end else begin
            for (int p = 0; p < NWR; p++) begin
                if (we_i[p] && (waddr_i[p*AW +: AW] != '0)) begin
                    mem_q[waddr_i[p*AW +: AW]] <= wdata_i[p*DW +: DW];
                    tok_q[waddr_i[p*AW +: AW]] <= wtok_i[p];
                end
            end
        end
    end

    generate
        for (genvar g = 0; g < NRD; g++) begin : g_rd
            logic [AW-1:0] ra;
            assign ra                   = raddr_i[g*AW +: AW];
            assign rdata_o[g*DW +: DW]  = (ra == '0) ? '0 : mem_q[ra];
            assign rtok_o[g]            = (ra == '0) ? 1'b0 : tok_q[ra];
        end
    endgenerate

    assign tok_all_o = tok_q;

    // R8
    top_lane_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i[TOP] && waddr_i[TOP*AW +: AW] != '0)
        |=> (mem_q[$past(waddr_i[TOP*AW +: AW])] == $past(wdata_i[TOP*DW +: DW]))
            && (tok_q[$past(waddr_i[TOP*AW +: AW])] == $past(wtok_i[TOP])));

    // R5
    low_lane_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i[0] && waddr_i[0 +: AW] != '0
         && !(we_i[TOP] && waddr_i[TOP*AW +: AW] == waddr_i[0 +: AW]))
        |=> (mem_q[$past(waddr_i[0 +: AW])] == $past(wdata_i[0 +: DW])));
endmodule

// File: rtl/tokreg_chk.sv
`timescale 1ns/1ps
module tokreg_chk
    import tokreg_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit_i,
    input  logic [DW-1:0] target_i,
    output logic          redirect_o,
    output logic [DW-1:0] target_o
);
    chk_state_e    state_q, state_d;
    logic [DW-1:0] target_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= CHK_IDLE;
            target_q <= '0;
        end else begin
            state_q <= state_d;
            if (hit_i) target_q <= target_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CHK_IDLE: state_d = hit_i ? CHK_FIRE : CHK_IDLE;
            CHK_FIRE: state_d = hit_i ? CHK_FIRE : CHK_IDLE;
        endcase
    end

    always_comb begin
        redirect_o = (state_q == CHK_FIRE);
        target_o   = target_q;
    end

    // R3
    hit_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> redirect_o && (target_o == $past(target_i)));

    // R4
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_i |=> !redirect_o);
endmodule

// File: rtl/tokreg_file.sv
`timescale 1ns/1ps
module tokreg_file
    import tokreg_pkg::*;
#(
    parameter int NREG   = 32,
    parameter int DW     = 64,
    parameter int NUM_WR = 2,
    parameter int NUM_RD = 2,
    parameter int AW     = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WR*3-1:0]  wr_op_i,
    input  logic [NUM_WR*AW-1:0] wr_dst_i,
    input  logic [NUM_WR*AW-1:0] wr_srca_i,
    input  logic [NUM_WR*AW-1:0] wr_srcb_i,
    input  logic [NUM_WR*DW-1:0] wr_data_i,
    input  logic [NUM_WR-1:0]    wr_fault_i,
    input  logic                 chk_valid_i,
    input  logic [AW-1:0]        chk_reg_i,
    input  logic [DW-1:0]        chk_target_i,
    input  logic [NUM_RD*AW-1:0] rd_addr_i,
    output logic [NUM_RD*DW-1:0] rd_data_o,
    output logic [NUM_RD-1:0]    rd_tok_o,
    output logic [NUM_WR-1:0]    fault_o,
    output logic                 redirect_o,
    output logic [DW-1:0]        redirect_pc_o
);
    localparam int TOP = NUM_WR - 1;

    logic [NREG-1:0]   tok_all;
    logic [NUM_WR-1:0] lane_we, lane_tok, lane_flt;
    logic [NUM_WR-1:0] tok_a, tok_b;
    logic [2:0]        lane_op  [NUM_WR];
    logic [AW-1:0]     lane_dst [NUM_WR];
    logic [NUM_WR-1:0] fault_q;
    logic              chk_hit;

    generate
        for (genvar g = 0; g < NUM_WR; g++) begin : g_lane
            assign lane_op[g]  = wr_op_i[g*3 +: 3];
            assign lane_dst[g] = wr_dst_i[g*AW +: AW];
            assign tok_a[g]    = tok_all[wr_srca_i[g*AW +: AW]];
            assign tok_b[g]    = tok_all[wr_srcb_i[g*AW +: AW]];

            tokreg_lane #(.AW(AW)) u_lane (
                .op_i    (lane_op[g]),
                .dst_i   (lane_dst[g]),
                .fault_i (wr_fault_i[g]),
                .tok_a_i (tok_a[g]),
                .tok_b_i (tok_b[g]),
                .we_o    (lane_we[g]),
                .tok_o   (lane_tok[g]),
                .fault_o (lane_flt[g])
            );

            // R6
            nonspec_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ((lane_op[g] == OP_ALU && (tok_a[g] || tok_b[g]))
                 || (lane_op[g] == OP_LD && (tok_a[g] || wr_fault_i[g])))
                |=> fault_o[g]);
        end
    endgenerate

    tokreg_store #(
        .NREG(NREG), .DW(DW), .NWR(NUM_WR), .NRD(NUM_RD), .AW(AW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (lane_we),
        .waddr_i   (wr_dst_i),
        .wdata_i   (wr_data_i),
        .wtok_i    (lane_tok),
        .raddr_i   (rd_addr_i),
        .rdata_o   (rd_data_o),
        .rtok_o    (rd_tok_o),
        .tok_all_o (tok_all)
    );

    assign chk_hit = chk_valid_i && tok_all[chk_reg_i];

    tokreg_chk #(.DW(DW)) u_chk (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (chk_hit),
        .target_i   (chk_target_i),
        .redirect_o (redirect_o),
        .target_o   (redirect_pc_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fault_q <= '0;
        else        fault_q <= lane_flt;
    end
    assign fault_o = fault_q;

    // R1
    spec_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_op[TOP] == OP_LDS && wr_fault_i[TOP] && lane_dst[TOP] != '0)
        |=> tok_all[$past(lane_dst[TOP])] && !fault_o[TOP]);

    // R2
    spec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_op[TOP] == OP_ALUS && (tok_a[TOP] || tok_b[TOP]) && lane_dst[TOP] != '0)
        |=> tok_all[$past(lane_dst[TOP])]);

    // R7
    zero_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_dst[0] == '0) |=> !tok_all[0]);
endmodule

// File: tb/tb_tokreg_file.sv
`timescale 1ns/1ps
module tb_tokreg_file;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [2:0]  op  [2];
    logic [4:0]  dst [2];
    logic [4:0]  sa  [2];
    logic [4:0]  sb  [2];
    logic [63:0] dat [2];
    logic [1:0]  flt;
    logic        chk_v;
    logic [4:0]  chk_r;
    logic [63:0] chk_t;
    logic [4:0]  ra [2];

    logic [127:0] rd_data;
    logic [1:0]   rd_tok;
    logic [1:0]   fault;
    logic         redirect;
    logic [63:0]  redirect_pc;

    tokreg_file dut (
        .clk(clk), .rst_n(rst_n),
        .wr_op_i({op[1], op[0]}), .wr_dst_i({dst[1], dst[0]}),
        .wr_srca_i({sa[1], sa[0]}), .wr_srcb_i({sb[1], sb[0]}),
        .wr_data_i({dat[1], dat[0]}), .wr_fault_i(flt),
        .chk_valid_i(chk_v), .chk_reg_i(chk_r), .chk_target_i(chk_t),
        .rd_addr_i({ra[1], ra[0]}), .rd_data_o(rd_data), .rd_tok_o(rd_tok),
        .fault_o(fault), .redirect_o(redirect), .redirect_pc_o(redirect_pc)
    );

    logic [63:0] m_data [32];
    logic        m_tok  [32];
    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // returns {we, tok, fault}
    function automatic logic [2:0] lane_eval(input logic [2:0] o, input logic [4:0] d,
                                             input logic f, input logic ta, input logic tb);
        logic we, tk, fl;
        we = 0; tk = 0; fl = 0;
        case (o)
            3'd1: if (f || ta) fl = 1; else we = 1;
            3'd2: begin we = 1; tk = f | ta; end
            3'd3: if (ta || tb) fl = 1; else we = 1;
            3'd4: begin we = 1; tk = ta | tb; end
            default: ;
        endcase
        if (d == 0) we = 0;
        return {we, tk, fl};
    endfunction

    task automatic idle_inputs();
        for (int p = 0; p < 2; p++) begin
            op[p] = 0; dst[p] = 0; sa[p] = 0; sb[p] = 0; dat[p] = 0;
        end
        flt = 0; chk_v = 0; chk_r = 0; chk_t = 0;
    endtask

    task automatic set_lane(input int p, input logic [2:0] o, input logic [4:0] d,
                            input logic [4:0] a, input logic [4:0] b,
                            input logic [63:0] v, input logic f);
        op[p] = o; dst[p] = d; sa[p] = a; sb[p] = b; dat[p] = v; flt[p] = f;
    endtask

    task automatic do_cycle(input string tag);
        logic [2:0] res [2];
        logic [1:0] exp_f;
        logic exp_r;
        logic [63:0] exp_pc;
        for (int p = 0; p < 2; p++) begin
            res[p] = lane_eval(op[p], dst[p], flt[p], m_tok[sa[p]], m_tok[sb[p]]);
            exp_f[p] = res[p][0];
        end
        exp_r  = chk_v && m_tok[chk_r];
        exp_pc = chk_t;
        @(posedge clk);
        for (int p = 0; p < 2; p++) begin
            if (res[p][2]) begin
                m_data[dst[p]] = dat[p];
                m_tok[dst[p]]  = res[p][1];
            end
        end
        @(negedge clk);
        chk({tag, " R6 fault"}, {62'd0, fault}, {62'd0, exp_f});
        chk({tag, " R3/R4 redirect"}, {63'd0, redirect}, {63'd0, exp_r});
        if (exp_r) chk({tag, " R3 target"}, redirect_pc, exp_pc);
        idle_inputs();
    endtask

    task automatic check_reads(input string tag, input logic [4:0] a0, input logic [4:0] a1);
        ra[0] = a0; ra[1] = a1;
        #1;
        chk({tag, " data0"}, rd_data[63:0], m_data[a0]);
        chk({tag, " tok0"}, {63'd0, rd_tok[0]}, {63'd0, m_tok[a0]});
        chk({tag, " data1"}, rd_data[127:64], m_data[a1]);
        chk({tag, " tok1"}, {63'd0, rd_tok[1]}, {63'd0, m_tok[a1]});
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int r = 0; r < 32; r++) begin m_data[r] = 0; m_tok[r] = 0; end
        idle_inputs();
        ra[0] = 0; ra[1] = 0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 fault", {62'd0, fault}, 64'd0);
        chk("R10 redirect", {63'd0, redirect}, 64'd0);
        check_reads("R10", 5'd1, 5'd31);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 clean writes
        set_lane(0, 3'd1, 5'd1, 5'd0, 5'd0, 64'hAAAA_0001, 1'b0);
        set_lane(1, 3'd3, 5'd2, 5'd1, 5'd0, 64'hBBBB_0002, 1'b0);
        do_cycle("R5");
        check_reads("R5", 5'd1, 5'd2);

        // R1 speculative load with fault
        set_lane(0, 3'd2, 5'd3, 5'd0, 5'd0, 64'h3333, 1'b1);
        do_cycle("R1");
        check_reads("R1", 5'd3, 5'd1);

        // R2 chain: second load uses poisoned r3 as address
        set_lane(1, 3'd2, 5'd4, 5'd3, 5'd0, 64'h4444, 1'b0);
        do_cycle("R2");
        check_reads("R2", 5'd4, 5'd3);
        chk_v = 1; chk_r = 5'd4; chk_t = 64'hDEAD_BEEF_0000_4000;
        do_cycle("R3 chain");
        chk("R3 one-cycle pulse", {63'd0, redirect}, 64'd1);
        @(negedge clk);
        chk("R3 pulse ends", {63'd0, redirect}, 64'd0);

        // R4 verify on clean register
        chk_v = 1; chk_r = 5'd1; chk_t = 64'h1234;
        do_cycle("R4");
        check_reads("R4", 5'd1, 5'd2);

        // R6 non-speculative use of poison, and a load fault on lane 1
        set_lane(0, 3'd3, 5'd5, 5'd4, 5'd1, 64'h5555, 1'b0);
        set_lane(1, 3'd1, 5'd6, 5'd1, 5'd0, 64'h6666, 1'b1);
        do_cycle("R6");
        check_reads("R6", 5'd5, 5'd6);

        // R5 clean load clears poison on r3
        set_lane(0, 3'd1, 5'd3, 5'd1, 5'd0, 64'h7777, 1'b0);
        do_cycle("R5 clear");
        check_reads("R5 clear", 5'd3, 5'd4);

        // R7 register zero
        set_lane(0, 3'd1, 5'd0, 5'd0, 5'd0, 64'hFFFF_FFFF, 1'b0);
        set_lane(1, 3'd2, 5'd0, 5'd0, 5'd0, 64'hEEEE, 1'b1);
        do_cycle("R7");
        check_reads("R7", 5'd0, 5'd0);
        chk_v = 1; chk_r = 5'd0; chk_t = 64'h99;
        do_cycle("R7 verify");

        // R8 both lanes target r6
        set_lane(0, 3'd2, 5'd6, 5'd0, 5'd0, 64'h0101, 1'b1);
        set_lane(1, 3'd1, 5'd6, 5'd0, 5'd0, 64'h0202, 1'b0);
        do_cycle("R8");
        check_reads("R8", 5'd6, 5'd6);
        set_lane(0, 3'd1, 5'd7, 5'd0, 5'd0, 64'h0303, 1'b0);
        set_lane(1, 3'd2, 5'd7, 5'd0, 5'd0, 64'h0404, 1'b1);
        do_cycle("R8 tok");
        check_reads("R8 tok", 5'd7, 5'd6);

        // R9 no same-cycle forwarding: r8 was clean before the edge
        set_lane(0, 3'd2, 5'd8, 5'd0, 5'd0, 64'h0808, 1'b1);
        set_lane(1, 3'd4, 5'd9, 5'd8, 5'd0, 64'h0909, 1'b0);
        chk_v = 1; chk_r = 5'd8; chk_t = 64'h88;
        do_cycle("R9");
        check_reads("R9", 5'd8, 5'd9);
        set_lane(1, 3'd4, 5'd9, 5'd8, 5'd0, 64'h0A0A, 1'b0);
        do_cycle("R9 next");
        check_reads("R9 next", 5'd9, 5'd8);

        // random mix covering R1-R9 against the model
        for (int i = 0; i < 3000; i++) begin
            for (int p = 0; p < 2; p++) begin
                set_lane(p, 3'($urandom % 5), 5'($urandom), 5'($urandom), 5'($urandom),
                         {$urandom, $urandom}, ($urandom % 4) == 0);
            end
            chk_v = ($urandom % 3) == 0;
            chk_r = 5'($urandom);
            chk_t = {$urandom, $urandom};
            do_cycle("R2 random");
            check_reads("R5 random", 5'($urandom), 5'($urandom));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule